// File: doc/BRIEF.md
# Deferred Floating-Point Trap Queue Replay Sequencer

This block replays floating-point operations that were held back when a deferred floating-point trap was taken. A start pulse captures the number of valid queue entries, the trapping PC and nPC, and the floating-point status word. The block then sends each queued instruction word, with its address, to an external execution unit. The handshake is a one-cycle `exec_valid` pulse answered later by an `exec_done` pulse that carries an `exec_ok` result. Entries go out strictly one at a time in index order. The replay stops at the first entry the unit rejects. At the end the block clears the status bits that flag a non-empty queue, clears the current-exception field only when every replayed entry succeeded, and sets the depth to zero.

A depth of zero at start marks the trap as precise. The block then issues only the instruction word fetched at the trapping PC, presented on `precise_insn`. When that instruction succeeds, PC takes the old nPC and nPC takes the old nPC plus 4. The status word is left unchanged in this case.

The controller has four states:
- `ST_IDLE` waits for `start`. It goes to `ST_ISSUE` when `start` is high.
- `ST_ISSUE` drives the `exec_valid` pulse for one cycle. It always goes to `ST_WAIT`.
- `ST_WAIT` waits for `exec_done`. It goes back to `ST_ISSUE` if the result is a success and more entries remain. Otherwise it goes to `ST_FINISH`.
- `ST_FINISH` drives the `complete` pulse and returns to `ST_IDLE`.

Top module: `fpq_replay_seq`

## Requirements
- R1: After reset, `busy`, `exec_valid` and `complete` are 0, `q_depth` is 0, and the PC, nPC and status outputs are 0.
- R2: A start with `q_depth_in` equal to 0 issues exactly one operation, with `exec_insn` = `precise_insn` and `exec_addr` = the captured trapping PC.
- R3: In the precise case, a success sets `pc_out` to the old nPC and `npc_out` to the old nPC + 4. A failure leaves both at their captured values.
- R4: With a non-zero depth, the entries are issued in index order from 0. Entry i is bits [32i+31:32i] of `q_insn_flat` and of `q_addr_flat`. `exec_valid` is a one-cycle pulse, and the next pulse comes only after `exec_done` for the previous one.
- R5: The first entry that returns `exec_ok` = 0 ends the replay. No later entry is issued.
- R6: After a queue replay, whatever its outcome, status bits 13:12 are 0 and `q_depth` is 0.
- R7: After a queue replay, status bits 4:0 are cleared only if every issued entry succeeded. All other status bits keep their captured values.
- R8: `busy` is high from the cycle after the start edge through the `complete` cycle. `complete` is a one-cycle pulse in the cycle after the edge that samples the last `exec_done`, and `all_ok` gives the overall result.
- R9: A `start` that arrives while `busy` is high has no effect: no extra issue, no change to the results, and no run afterwards.
- R10: In the precise case the status word is not modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a replay; sampled only when idle |
| q_depth_in | input | $clog2(QDEPTH+1) | Number of valid queue entries |
| q_insn_flat | input | QDEPTH*XLEN | Queued instruction words, entry i in slice i |
| q_addr_flat | input | QDEPTH*XLEN | Queued instruction addresses, entry i in slice i |
| precise_insn | input | XLEN | Instruction word fetched at the trapping PC |
| trap_pc_in | input | XLEN | Trapping PC |
| trap_npc_in | input | XLEN | Trapping nPC |
| status_in | input | XLEN | Floating-point status word |
| exec_done | input | 1 | Execution unit finished the issued operation |
| exec_ok | input | 1 | Result of that operation (1 = success) |
| exec_valid | output | 1 | Issue pulse to the execution unit |
| exec_insn | output | XLEN | Instruction word being issued |
| exec_addr | output | XLEN | Address of the issued instruction |
| busy | output | 1 | Replay in progress |
| complete | output | 1 | One-cycle end-of-replay pulse |
| all_ok | output | 1 | Every issued operation succeeded |
| q_depth | output | $clog2(QDEPTH+1) | Current queue depth |
| pc_out | output | XLEN | Resulting PC |
| npc_out | output | XLEN | Resulting nPC |
| status_out | output | XLEN | Resulting status word |

## Verification
The first `exec_valid` pulse is due one cycle after the edge that samples `start`. `complete` and the updated PC, nPC, status and depth are due one cycle after the edge that samples the final `exec_done`. The bench samples on falling edges and stamps each `exec_done` it drives with a rising-edge cycle count. At `complete` it checks that exactly one cycle has passed since that stamp. It also varies the response delay of its execution model per issue, so a result that arrives one cycle early or late shows up as a mismatch in the stamp check.

// File: rtl/fpq_pkg.sv
package fpq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_FINISH
    } seq_state_e;

    // status word fields whose positions the surrounding logic decodes
    localparam int QNE_LO    = 12;
    localparam int QNE_HI    = 13;
    localparam int CEXC_LO   = 0;
    localparam int CEXC_W    = 5;
    localparam int PC_STEP   = 4;

endpackage

// File: rtl/fpq_entry_mux.sv
module fpq_entry_mux #(
    parameter int QDEPTH = 4,
    parameter int XLEN   = 32,
    parameter int IW     = 2
) (
    input  logic [QDEPTH*XLEN-1:0] q_insn_flat,
    input  logic [QDEPTH*XLEN-1:0] q_addr_flat,
    input  logic [IW-1:0]          idx,
    input  logic                   precise,
    input  logic [XLEN-1:0]        precise_insn,
    input  logic [XLEN-1:0]        trap_pc,
    output logic [XLEN-1:0]        sel_insn,
    output logic [XLEN-1:0]        sel_addr
);

    logic [XLEN-1:0] insn_arr [QDEPTH];
    logic [XLEN-1:0] addr_arr [QDEPTH];

    for (genvar g = 0; g < QDEPTH; g++) begin : g_unpack
        assign insn_arr[g] = q_insn_flat[g*XLEN +: XLEN];
        assign addr_arr[g] = q_addr_flat[g*XLEN +: XLEN];
    end

    always_comb begin
        sel_insn = '0;
        sel_addr = '0;
        if (precise) begin
            sel_insn = precise_insn;
            sel_addr = trap_pc;
        end else begin
            for (int i = 0; i < QDEPTH; i++) begin
                if (IW'(i) == idx) begin
                    sel_insn = insn_arr[i];
                    sel_addr = addr_arr[i];
                end
            end
        end
    end

endmodule

// File: rtl/fpq_status_fix.sv
module fpq_status_fix
    import fpq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] status_in,
    input  logic            all_ok,
    output logic [XLEN-1:0] status_out
);

    localparam logic [XLEN-1:0] QNE_MASK  = XLEN'((2 ** (QNE_HI - QNE_LO + 1) - 1) << QNE_LO);
    localparam logic [XLEN-1:0] CEXC_MASK = XLEN'((2 ** CEXC_W - 1) << CEXC_LO);

    logic [XLEN-1:0] clr_mask;

    always_comb begin
        clr_mask = QNE_MASK;
        if (all_ok) begin
            clr_mask = clr_mask | CEXC_MASK;
        end
        status_out = status_in & ~clr_mask;
    end

endmodule

// File: rtl/fpq_pc_step.sv
module fpq_pc_step
    import fpq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] npc_in,
    output logic [XLEN-1:0] pc_next,
    output logic [XLEN-1:0] npc_next
);

    assign pc_next  = npc_in;
    assign npc_next = npc_in + XLEN'(PC_STEP);

endmodule

// File: rtl/fpq_replay_seq.sv
module fpq_replay_seq
    import fpq_pkg::*;
#(
    parameter int QDEPTH = 4,
    parameter int XLEN   = 32,
    localparam int DW    = $clog2(QDEPTH + 1),
    localparam int IW    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [DW-1:0]          q_depth_in,
    input  logic [QDEPTH*XLEN-1:0] q_insn_flat,
    input  logic [QDEPTH*XLEN-1:0] q_addr_flat,
    input  logic [XLEN-1:0]        precise_insn,
    input  logic [XLEN-1:0]        trap_pc_in,
    input  logic [XLEN-1:0]        trap_npc_in,
    input  logic [XLEN-1:0]        status_in,
    input  logic                   exec_done,
    input  logic                   exec_ok,
    output logic                   exec_valid,
    output logic [XLEN-1:0]        exec_insn,
    output logic [XLEN-1:0]        exec_addr,
    output logic                   busy,
    output logic                   complete,
    output logic                   all_ok,
    output logic [DW-1:0]          q_depth,
    output logic [XLEN-1:0]        pc_out,
    output logic [XLEN-1:0]        npc_out,
    output logic [XLEN-1:0]        status_out
);

    seq_state_e state, state_nx;

    logic [IW-1:0]   idx;
    logic [DW-1:0]   depth_r;
    logic            precise_r;
    logic            ok_r;
    logic [XLEN-1:0] pc_r;
    logic [XLEN-1:0] npc_r;
    logic [XLEN-1:0] st_r;

    logic            last_entry;
    logic            step_on;
    logic [XLEN-1:0] st_clean;
    logic [XLEN-1:0] pc_nx;
    logic [XLEN-1:0] npc_nx;

    assign last_entry = ((DW'(idx) + DW'(1)) == depth_r);
    assign step_on    = exec_ok && !precise_r && !last_entry;

    fpq_entry_mux #(
        .QDEPTH (QDEPTH),
        .XLEN   (XLEN),
        .IW     (IW)
    ) u_mux (
        .q_insn_flat  (q_insn_flat),
        .q_addr_flat  (q_addr_flat),
        .idx          (idx),
        .precise      (precise_r),
        .precise_insn (precise_insn),
        .trap_pc      (pc_r),
        .sel_insn     (exec_insn),
        .sel_addr     (exec_addr)
    );

    fpq_status_fix #(
        .XLEN (XLEN)
    ) u_stfix (
        .status_in  (st_r),
        .all_ok     (exec_ok),
        .status_out (st_clean)
    );

    fpq_pc_step #(
        .XLEN (XLEN)
    ) u_pcstep (
        .npc_in   (npc_r),
        .pc_next  (pc_nx),
        .npc_next (npc_nx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_ISSUE;
            ST_ISSUE:  state_nx = ST_WAIT;
            ST_WAIT: begin
                if (exec_done) begin
                    state_nx = step_on ? ST_ISSUE : ST_FINISH;
                end
            end
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        exec_valid = 1'b0;
        busy       = 1'b1;
        complete   = 1'b0;
        unique case (state)
            ST_IDLE:   busy       = 1'b0;
            ST_ISSUE:  exec_valid = 1'b1;
            ST_WAIT:   ;
            ST_FINISH: complete   = 1'b1;
            default:   busy       = 1'b0;
        endcase
    end

    // captured context and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            depth_r   <= '0;
            precise_r <= 1'b0;
            ok_r      <= 1'b0;
            pc_r      <= '0;
            npc_r     <= '0;
            st_r      <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                idx       <= '0;
                depth_r   <= q_depth_in;
                precise_r <= (q_depth_in == '0);
                ok_r      <= 1'b0;
                pc_r      <= trap_pc_in;
                npc_r     <= trap_npc_in;
                st_r      <= status_in;
            end else if (state == ST_WAIT && exec_done) begin
                if (step_on) begin
                    idx <= idx + IW'(1);
                end else begin
                    ok_r <= exec_ok;
                    if (precise_r) begin
                        if (exec_ok) begin
                            pc_r  <= pc_nx;
                            npc_r <= npc_nx;
                        end
                    end else begin
                        st_r    <= st_clean;
                        depth_r <= '0;
                    end
                end
            end
        end
    end

    assign all_ok     = ok_r;
    assign q_depth    = depth_r;
    assign pc_out     = pc_r;
    assign npc_out    = npc_r;
    assign status_out = st_r;

endmodule

// File: rtl/fpq_replay_chk.sv
module fpq_replay_chk
    import fpq_pkg::*;
#(
    parameter int DW   = 3,
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exec_valid,
    input logic            busy,
    input logic            complete,
    input logic            all_ok,
    input logic [DW-1:0]   q_depth,
    input logic [XLEN-1:0] status_out,
    input logic            precise_r
);

    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |=> !exec_valid);

    p_valid_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> busy);

    p_complete_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> (!complete && !busy));

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !complete) |=> busy);

    p_depth_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        complete |-> (q_depth == '0));

    p_qne_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (complete && !precise_r) |-> (status_out[QNE_HI:QNE_LO] == '0));

    p_cexc_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (complete && !precise_r && all_ok) |-> (status_out[CEXC_LO +: CEXC_W] == '0));

    p_precise_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (complete && precise_r) |-> $stable(status_out));

endmodule

bind fpq_replay_seq fpq_replay_chk #(
    .DW   (DW),
    .XLEN (XLEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_valid (exec_valid),
    .busy       (busy),
    .complete   (complete),
    .all_ok     (all_ok),
    .q_depth    (q_depth),
    .status_out (status_out),
    .precise_r  (precise_r)
);

// File: tb/tb_fpq_replay_seq.sv
module tb_fpq_replay_seq;

    localparam int CLK_PERIOD = 10;
    localparam int QDEPTH     = 4;
    localparam int XLEN       = 32;
    localparam int DW         = $clog2(QDEPTH + 1);
    localparam int WATCHDOG   = 100000;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic [DW-1:0]          q_depth_in = '0;
    logic [QDEPTH*XLEN-1:0] q_insn_flat = '0;
    logic [QDEPTH*XLEN-1:0] q_addr_flat = '0;
    logic [XLEN-1:0]        precise_insn = '0;
    logic [XLEN-1:0]        trap_pc_in = '0;
    logic [XLEN-1:0]        trap_npc_in = '0;
    logic [XLEN-1:0]        status_in = '0;
    logic                   exec_done = 1'b0;
    logic                   exec_ok = 1'b0;
    logic                   exec_valid;
    logic [XLEN-1:0]        exec_insn;
    logic [XLEN-1:0]        exec_addr;
    logic                   busy;
    logic                   complete;
    logic                   all_ok;
    logic [DW-1:0]          q_depth;
    logic [XLEN-1:0]        pc_out;
    logic [XLEN-1:0]        npc_out;
    logic [XLEN-1:0]        status_out;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int done_cyc = 0;
    int n_issue  = 0;
    int fail_idx = 99;
    int wait_cnt = 0;
    logic [XLEN-1:0] log_insn [8];
    logic [XLEN-1:0] log_addr [8];

    fpq_replay_seq #(
        .QDEPTH (QDEPTH),
        .XLEN   (XLEN)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .q_depth_in   (q_depth_in),
        .q_insn_flat  (q_insn_flat),
        .q_addr_flat  (q_addr_flat),
        .precise_insn (precise_insn),
        .trap_pc_in   (trap_pc_in),
        .trap_npc_in  (trap_npc_in),
        .status_in    (status_in),
        .exec_done    (exec_done),
        .exec_ok      (exec_ok),
        .exec_valid   (exec_valid),
        .exec_insn    (exec_insn),
        .exec_addr    (exec_addr),
        .busy         (busy),
        .complete     (complete),
        .all_ok       (all_ok),
        .q_depth      (q_depth),
        .pc_out       (pc_out),
        .npc_out      (npc_out),
        .status_out   (status_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ent_insn(input int d, input int i);
        return {16'hF00D, 8'(d), 8'(i)};
    endfunction

    function automatic logic [31:0] ent_addr(input int d, input int i);
        return 32'h4000_0000 + 32'(d * 64) + 32'(i * 4);
    endfunction

    // execution unit model: answers each issue after a varying delay
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            exec_done = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    exec_done = 1'b1;
                    exec_ok   = ((n_issue - 1) != fail_idx);
                    done_cyc  = cyc;
                end
            end else if (exec_valid) begin
                if (n_issue < 8) begin
                    log_insn[n_issue] = exec_insn;
                    log_addr[n_issue] = exec_addr;
                end
                cnt = 1 + (n_issue % 3);
                n_issue++;
            end
        end
    end

    task automatic run_case(input int d, input int f, input bit poke);
        logic [31:0] st, pc, npc, exp_st, exp_pc, exp_npc;
        int exp_n;
        bit exp_ok;
        st  = 32'hA5A5_F3FF ^ 32'(d * 32'h0101) ^ 32'(f << 20);
        pc  = 32'h0000_8000 + 32'(d * 16);
        npc = pc + 32'd4;
        @(negedge clk);
        for (int i = 0; i < QDEPTH; i++) begin
            q_insn_flat[i*XLEN +: XLEN] = ent_insn(d, i);
            q_addr_flat[i*XLEN +: XLEN] = ent_addr(d, i);
        end
        precise_insn = 32'hC0DE_0000 | 32'(f);
        trap_pc_in   = pc;
        trap_npc_in  = npc;
        status_in    = st;
        q_depth_in   = DW'(d);
        n_issue      = 0;
        fail_idx     = f;
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8 busy after start", 32'(busy), 32'd1);
        chk(exec_valid == 1'b1, "R4 first issue timing", 32'(exec_valid), 32'd1);
        if (poke) begin
            @(negedge clk);
            start      = 1'b1;
            q_depth_in = DW'(1);
            status_in  = 32'hFFFF_FFFF;
            @(negedge clk);
            start = 1'b0;
        end
        wait_cnt = 0;
        while (!complete && wait_cnt < 200) begin
            @(negedge clk);
            wait_cnt++;
        end
        chk(complete == 1'b1, "R8 complete seen", 32'(complete), 32'd1);
        chk(cyc == done_cyc + 1, "R8 complete one cycle after done", 32'(cyc), 32'(done_cyc + 1));
        if (d == 0) begin
            exp_n   = 1;
            exp_ok  = (f != 0);
            exp_st  = st;
            exp_pc  = exp_ok ? npc : pc;
            exp_npc = exp_ok ? npc + 32'd4 : npc;
            chk(n_issue == 1, "R2 single precise issue", 32'(n_issue), 32'd1);
            chk(log_insn[0] == precise_insn, "R2 precise insn", log_insn[0], precise_insn);
            chk(log_addr[0] == pc, "R2 precise addr", log_addr[0], pc);
            chk(pc_out == exp_pc, "R3 pc", pc_out, exp_pc);
            chk(npc_out == exp_npc, "R3 npc", npc_out, exp_npc);
            chk(status_out == exp_st, "R10 status untouched", status_out, exp_st);
        end else begin
            exp_n   = (f < d) ? f + 1 : d;
            exp_ok  = (f >= d);
            exp_st  = exp_ok ? (st & ~32'h0000_301F) : (st & ~32'h0000_3000);
            chk(n_issue == exp_n, "R5 issue count", 32'(n_issue), 32'(exp_n));
            for (int i = 0; i < exp_n; i++) begin
                chk(log_insn[i] == ent_insn(d, i), "R4 order insn", log_insn[i], ent_insn(d, i));
                chk(log_addr[i] == ent_addr(d, i), "R4 order addr", log_addr[i], ent_addr(d, i));
            end
            chk(status_out[13:12] == 2'b00, "R6 queue flag cleared", 32'(status_out[13:12]), 32'd0);
            chk(status_out == exp_st, "R7 status result", status_out, exp_st);
            chk(pc_out == pc, "R4 pc unchanged by queue", pc_out, pc);
        end
        chk(all_ok == exp_ok, "R8 all_ok", 32'(all_ok), 32'(exp_ok));
        chk(q_depth == '0, "R6 depth zero", 32'(q_depth), 32'd0);
        @(negedge clk);
        chk(busy == 1'b0 && complete == 1'b0, "R8 idle after complete", {30'd0, busy, complete}, 32'd0);
        if (poke) begin
            repeat (4) @(negedge clk);
            chk(busy == 1'b0 && n_issue == exp_n, "R9 start while busy ignored",
                32'(n_issue), 32'(exp_n));
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0 && exec_valid == 1'b0 && complete == 1'b0, "R1 idle in reset",
            {29'd0, busy, exec_valid, complete}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(q_depth == '0, "R1 depth", 32'(q_depth), 32'd0);
        chk(pc_out == '0 && npc_out == '0 && status_out == '0, "R1 context", pc_out | npc_out | status_out, 32'd0);
        // precise trap: success and failure
        run_case(0, 99, 1'b0);
        run_case(0, 0, 1'b0);
        // queue sweep: every depth, every fail position and no failure
        for (int d = 1; d <= QDEPTH; d++) begin
            for (int f = 0; f <= d; f++) begin
                run_case(d, (f == d) ? 99 : f, (d == 3 && f == d));
            end
        end
        run_case(2, 1, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule